// File: doc/BRIEF.md
# CAN Test-Mode Pin Controller

This block sits between a CAN protocol core and the two bus pins. It holds a small control register and decides, once per cycle, what level leaves on the transmit pin and which level the core sees as its receive input. The transmit pin can follow the core, show the core's sample-point pulse, or be forced dominant or recessive. A silent setting keeps the core off the bus. Two loopback settings feed the core's own transmit level back to its receive input: the internal one also holds the pin recessive, and the external one keeps driving the pin.

The receive pin passes through a synchronizer. Its synchronized level feeds the core and is also readable as a monitor bit in the register. The control fields can change only while the test-enable input is high. This keeps ordinary software from putting the bus into a test setting by accident.

Top module: `can_testmode_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, all control fields read 0. The synchronizer holds recessive (1), so the register reads 0x080 until a different pin level has passed through.
- R2: When the TX mode field (bits 6:5) is 00 and neither silent nor internal-only loopback is active, `can_tx` equals `core_tx` in the same cycle.
- R3: TX mode 01 puts `sample_pt` on `can_tx` in the same cycle. This overrides silent and loopback.
- R4: TX mode 10 forces `can_tx` to 0 (dominant). TX mode 11 forces it to 1 (recessive). Both override silent and loopback.
- R5: With silent (bit 3) set and TX mode 00, `can_tx` is 1 whatever `core_tx` does.
- R6: With loopback (bit 4) set, external loopback (bit 8) clear and TX mode 00, `can_tx` is 1 and `core_rx` equals `core_tx`.
- R7: With external loopback (bit 8) set, `core_rx` equals `core_tx`, and `can_tx` still follows the TX mode.
- R8: With both loopback bits clear, `core_rx` equals the level that `can_rx` had two rising clock edges earlier.
- R9: Register layout: bit 8 external loopback, bit 7 receive monitor, bits 6:5 TX mode, bit 4 loopback, bit 3 silent. All other bits read 0. The monitor bit shows the synchronized `can_rx` level (0 dominant, 1 recessive) and ignores writes. A write takes effect at the clock edge where `reg_wr` is sampled high.
- R10: A write with `test_en` low leaves every control field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Write permission for the control fields |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| core_tx | input | 1 | Transmit level from the protocol core |
| sample_pt | input | 1 | Sample-point pulse from the core |
| core_rx | output | 1 | Receive level presented to the core |
| can_tx | output | 1 | Transmit pin |
| can_rx | input | 1 | Receive pin (asynchronous) |

## Verification
On every cycle, the assertions check the forced and sample-point pin levels, the silent and loopback pin behaviour, the two-edge receive latency, the zero unused bits, and the write protection. All of them are stated against the read-back register, so they do not depend on internal state. Only the bench scenarios can show the full pin-selection priority across all 32 field combinations. The same goes for writes of all-ones data that try to set the read-only monitor bit, and for the value read during reset.

// File: rtl/can_tm_pkg.sv
`timescale 1ns/1ps
package can_tm_pkg;

   localparam int POS_EXT_LB  = 8;
   localparam int POS_RX_MON  = 7;
   localparam int POS_TXM_HI  = 6;
   localparam int POS_TXM_LO  = 5;
   localparam int POS_LB      = 4;
   localparam int POS_SILENT  = 3;
   localparam int MIN_DATA_W  = POS_EXT_LB + 1;

   typedef enum logic [1:0] {
      TXM_CORE   = 2'b00,
      TXM_SAMPLE = 2'b01,
      TXM_DOM    = 2'b10,
      TXM_REC    = 2'b11
   } txm_e;

   typedef struct packed {
      logic ext_lb;
      txm_e txm;
      logic lb;
      logic silent;
   } tm_cfg_t;

endpackage

// File: rtl/can_tm_ctlreg.sv
`timescale 1ns/1ps
module can_tm_ctlreg
   import can_tm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_en,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_mon,
   output tm_cfg_t           cfg,
   output logic [DATA_W-1:0] rdata
);

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("can_tm_ctlreg: DATA_W too small for the register layout");
   end

   logic wr_ok;
   assign wr_ok = wr & test_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_ok) begin
         cfg.ext_lb <= wdata[POS_EXT_LB];
         cfg.txm    <= txm_e'(wdata[POS_TXM_HI:POS_TXM_LO]);
         cfg.lb     <= wdata[POS_LB];
         cfg.silent <= wdata[POS_SILENT];
      end
   end

   always_comb begin
      rdata                         = '0;
      rdata[POS_EXT_LB]             = cfg.ext_lb;
      rdata[POS_RX_MON]             = rx_mon;
      rdata[POS_TXM_HI:POS_TXM_LO]  = cfg.txm;
      rdata[POS_LB]                 = cfg.lb;
      rdata[POS_SILENT]             = cfg.silent;
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[DATA_W-1:MIN_DATA_W], wdata[POS_RX_MON], wdata[POS_SILENT-1:0]};

endmodule

// File: rtl/can_tm_rxsync.sv
`timescale 1ns/1ps
module can_tm_rxsync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("can_tm_rxsync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/can_tm_txsel.sv
`timescale 1ns/1ps
module can_tm_txsel
   import can_tm_pkg::*;
(
   input  tm_cfg_t cfg,
   input  logic    core_tx,
   input  logic    sample_pt,
   input  logic    rx_sync,
   output logic    pin_tx,
   output logic    to_core_rx
);

   logic hold_rec;
   logic loop_any;

   assign hold_rec = cfg.silent | (cfg.lb & ~cfg.ext_lb);
   assign loop_any = cfg.lb | cfg.ext_lb;

   always_comb begin
      unique case (cfg.txm)
         TXM_CORE:   pin_tx = hold_rec ? 1'b1 : core_tx;
         TXM_SAMPLE: pin_tx = sample_pt;
         TXM_DOM:    pin_tx = 1'b0;
         TXM_REC:    pin_tx = 1'b1;
         default:    pin_tx = 1'b1;
      endcase
   end

   assign to_core_rx = loop_any ? core_tx : rx_sync;

endmodule

// File: rtl/can_testmode_ctl.sv
`timescale 1ns/1ps
module can_testmode_ctl
   import can_tm_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_en,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              core_tx,
   input  logic              sample_pt,
   output logic              core_rx,
   output logic              can_tx,
   input  logic              can_rx
);

   tm_cfg_t cfg;
   logic    rx_s;

   can_tm_rxsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (can_rx),
      .q_sync  (rx_s)
   );

   can_tm_ctlreg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_en (test_en),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .rx_mon  (rx_s),
      .cfg     (cfg),
      .rdata   (reg_rdata)
   );

   can_tm_txsel u_sel (
      .cfg        (cfg),
      .core_tx    (core_tx),
      .sample_pt  (sample_pt),
      .rx_sync    (rx_s),
      .pin_tx     (can_tx),
      .to_core_rx (core_rx)
   );

endmodule

// File: rtl/can_tm_chk.sv
`timescale 1ns/1ps
module can_tm_chk #(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_en,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              core_tx,
   input logic              sample_pt,
   input logic              core_rx,
   input logic              can_tx,
   input logic              can_rx
);

   localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(9'h178);
   localparam logic [DATA_W-1:0] USED_MASK  = DATA_W'(9'h1F8);

   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc <= '0;
      else if (cyc != 3) cyc <= cyc + 2'd1;
   end

   wire [1:0] txm    = reg_rdata[6:5];
   wire       lb_int = reg_rdata[4];
   wire       lb_ext = reg_rdata[8];
   wire       sil    = reg_rdata[3];

   // R4
   forced_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txm == 2'b10) |-> (can_tx == 1'b0));
   // R4
   forced_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txm == 2'b11) |-> (can_tx == 1'b1));
   // R3
   sample_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txm == 2'b01) |-> (can_tx == sample_pt));
   // R5
   silent_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txm == 2'b00 && sil) |-> can_tx);
   // R6
   int_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txm == 2'b00 && lb_int && !lb_ext) |-> (can_tx && core_rx == core_tx));
   // R7
   ext_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lb_ext |-> (core_rx == core_tx));
   // R9
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rdata & ~USED_MASK) == '0));
   // R10
   write_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !test_en) |=> $stable(reg_rdata & FIELD_MASK));

   if (SYNC_STAGES == 2) begin : g_lat
      // R8
      rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc >= 2 && !lb_int && !lb_ext) |-> (core_rx == $past(can_rx, 2)));
   end

endmodule

bind can_testmode_ctl can_tm_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_en   (test_en),
   .reg_wr    (reg_wr),
   .reg_rdata (reg_rdata),
   .core_tx   (core_tx),
   .sample_pt (sample_pt),
   .core_rx   (core_rx),
   .can_tx    (can_tx),
   .can_rx    (can_rx)
);

// File: tb/can_testmode_ctl_test.sv
`timescale 1ns/1ps
module can_testmode_ctl_test;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        test_en = 0;
   logic        reg_wr = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        core_tx = 0;
   logic        sample_pt = 0;
   logic        core_rx;
   logic        can_tx;
   logic        can_rx = 1;

   always #4 clk = ~clk;

   can_testmode_ctl uut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_tx(core_tx),
      .sample_pt(sample_pt), .core_rx(core_rx), .can_tx(can_tx), .can_rx(can_rx)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   bit m_ext = 0, m_lb = 0, m_sil = 0;
   int m_txc = 0;
   bit rxq[$] = '{1'b1, 1'b1};
   bit last_blocked = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ext = 0; m_lb = 0; m_sil = 0; m_txc = 0;
         rxq = '{1'b1, 1'b1};
         last_blocked = 0;
      end else begin
         rxq.push_back(can_rx);
         void'(rxq.pop_front());
         last_blocked = reg_wr && !test_en;
         if (reg_wr && test_en) begin
            m_ext = reg_wdata[8];
            m_txc = int'(reg_wdata[6:5]);
            m_lb  = reg_wdata[4];
            m_sil = reg_wdata[3];
         end
      end
   end

   function automatic bit exp_tx();
      case (m_txc)
         0:       return (m_sil || (m_lb && !m_ext)) ? 1'b1 : core_tx;
         1:       return sample_pt;
         2:       return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         string ttag, rtag, dtag;
         bit er;
         logic [31:0] ed;
         if (m_txc == 1)                         ttag = "R3";
         else if (m_txc >= 2)                    ttag = "R4";
         else if (m_sil)                         ttag = "R5";
         else if (m_lb && !m_ext)                ttag = "R6";
         else if (m_ext)                         ttag = "R7";
         else                                    ttag = "R2";
         chk({ttag, " can_tx"}, {31'd0, can_tx}, {31'd0, exp_tx()});
         if (m_ext)      begin rtag = "R7"; er = core_tx; end
         else if (m_lb)  begin rtag = "R6"; er = core_tx; end
         else            begin rtag = "R8"; er = rxq[0];  end
         chk({rtag, " core_rx"}, {31'd0, core_rx}, {31'd0, er});
         ed = ({31'd0, m_ext} << 8) | ({31'd0, rxq[0]} << 7) |
              (32'(m_txc) << 5) | ({31'd0, m_lb} << 4) | ({31'd0, m_sil} << 3);
         dtag = last_blocked ? "R10" : "R9";
         chk({dtag, " reg_rdata"}, reg_rdata, ed);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         reg_wr    = 0;
         core_tx   = 1'($urandom);
         sample_pt = 1'($urandom);
         can_rx    = 1'($urandom);
      end
   endtask

   task automatic wr(logic [31:0] d, bit te);
      @(posedge clk); #1;
      reg_wr = 1; reg_wdata = d; test_en = te;
      core_tx = 1'($urandom); sample_pt = 1'($urandom); can_rx = 1'($urandom);
      @(posedge clk); #1;
      reg_wr = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset values
      core_tx = 0; can_rx = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset rdata", reg_rdata, 32'h80);
      chk("R1 reset can_tx", {31'd0, can_tx}, 32'd0);
      chk("R1 reset core_rx", {31'd0, core_rx}, 32'd1);
      @(posedge clk); #1 rst_n = 1;
      step(20);
      // R2 and R8 in default mode, then every field combination
      for (int m = 0; m < 32; m++) begin
         wr({23'd0, m[4], 1'b0, m[3:2], m[1], m[0], 3'b000}, 1'b1);
         step(12);
      end
      // R9: all-ones write, monitor bit and unused bits ignored
      wr(32'hFFFF_FFFF, 1'b1);
      step(10);
      // R10: blocked writes
      wr(32'h0000_0000, 1'b0);
      step(4);
      wr(32'h0000_0048, 1'b0);
      step(4);
      wr(32'h0000_0000, 1'b1);
      step(6);
      wr(32'hFFFF_FFFF, 1'b0);
      step(10);
      // R8: long run through the synchronizer
      step(60);
      finish_run();
   end

endmodule